// File: doc/BRIEF.md
# Indirect Register Access Window

This block sits on a 64-bit configuration bus and exposes a handful of registers that together open a window onto a larger internal register space. Software first writes a 12-bit internal address into the window-address register. A read of the window-data register then fetches that internal register over a downstream request port. A write to the window-data register sends the value to the selected internal register.

The block also holds a sticky status register that is cleared by writing ones to it, and two control slots that accept writes and ignore them. It also keeps a capture of the last offending register index. Only aligned 8-byte accesses are legal. Any other access, or a write to a slot that cannot take one, completes without effect and raises a one-cycle error pulse alongside the bus acknowledge.

A single state machine sequences every access. Its states are IDLE, DNRD (downstream read outstanding), DNWR (downstream write outstanding) and RESP (bus acknowledge). It has these transitions:
- IDLE to DNRD on a legal read of window data.
- IDLE to DNWR on a legal write of window data.
- IDLE to RESP on any other request.
- DNRD or DNWR to RESP when the downstream port signals ready.
- RESP to IDLE unconditionally.

Top module: `ibw_top`

## Requirements
- R1: After reset, cfg_ack, err_pulse and dn_valid are low, and every register (window address, status, error capture) reads back as zero.
- R2: The register index is the byte address shifted right by 3. Index 0 is the window address, 1 window data, 2 status, 3 and 4 control, and 5 the error capture. Bus data is big-endian: bits 7:0 of cfg_wdata/cfg_rdata carry the most significant byte of the register value, and so on down to bits 63:56 carrying the least significant byte.
- R3: A write to index 0 keeps only bits 11:0 of the value, which read back zero-extended at index 0 and drive dn_addr.
- R4: A legal read of index 1 issues one downstream read (dn_we low) at the window address and returns dn_rdata as the bus value.
- R5: A legal write of index 1 issues one downstream write (dn_we high) of the value to the window address.
- R6: dn_valid stays high with stable dn_addr, dn_we and dn_wdata until dn_ready. cfg_ack is a one-cycle pulse in the cycle after dn_ready for a window-data access, and one cycle after the request is accepted for any other access.
- R7: Status bit 0 records an illegal access and bit 1 a rejected write. A write to index 2 clears exactly the bits set in the value.
- R8: Writes to indices 3 and 4 raise no error, start no downstream access and change no readable state; both read as zero.
- R9: A legal write to index 5 or above changes nothing else, pulses err_pulse with cfg_ack, sets status bit 1 and captures the index at index 5.
- R10: An access whose size code is not 3 (8 bytes) or whose address bits 2:0 are non-zero has no effect and starts no downstream access. It returns zero, pulses err_pulse, sets status bit 0 and captures the index.
- R11: Legal reads of any index other than 1 raise no error and start no downstream access; indices 3, 4 and 6 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Bus request, held until cfg_ack, dropped after it |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_size | input | 2 | Access size code, log2 of bytes; only 3 is legal |
| cfg_addr | input | ADDR_W | Byte address |
| cfg_wdata | input | 64 | Write data, big-endian lanes |
| cfg_ack | output | 1 | One-cycle completion |
| cfg_rdata | output | 64 | Read data, valid with cfg_ack, else zero |
| err_pulse | output | 1 | One-cycle error flag, coincident with cfg_ack |
| dn_valid | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | WIN_AW | Downstream internal address |
| dn_wdata | output | 64 | Downstream write value |
| dn_ready | input | 1 | Downstream acknowledge |
| dn_rdata | input | 64 | Downstream read value, sampled with dn_ready |

## Verification
The bench builds the block with its default parameters: a 16-bit byte address (13-bit index) and a 12-bit window. These values let a bench-side model of all 4096 internal registers mirror the whole window. They also let the far index 8191 exercise the full width of the error capture. The downstream responder stalls for a chosen 0 to 3 cycles, which brings the held-request rule and the exact acknowledge latency within reach.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DNRD,
        ST_DNWR,
        ST_RESP
    } ibw_state_e;

    typedef enum logic [2:0] {
        K_WADDR,
        K_WDATA,
        K_STAT,
        K_CTRL,
        K_ECAP,
        K_OTHER
    } ibw_kind_e;
endpackage

// File: rtl/ibw_swap.sv
module ibw_swap #(
    parameter int BYTES = 8
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/ibw_decode.sv
module ibw_decode
    import ibw_pkg::*;
#(
    parameter int IDX_W     = 13,
    parameter int IDX_WADDR = 0,
    parameter int IDX_WDATA = 1,
    parameter int IDX_STAT  = 2,
    parameter int IDX_CTL0  = 3,
    parameter int IDX_CTL1  = 4,
    parameter int IDX_ECAP  = 5
) (
    input  logic [IDX_W-1:0] idx,
    output ibw_kind_e        kind
);
    always_comb begin
        if (idx == IDX_W'(IDX_WADDR))       kind = K_WADDR;
        else if (idx == IDX_W'(IDX_WDATA))  kind = K_WDATA;
        else if (idx == IDX_W'(IDX_STAT))   kind = K_STAT;
        else if (idx == IDX_W'(IDX_CTL0) ||
                 idx == IDX_W'(IDX_CTL1))   kind = K_CTRL;
        else if (idx == IDX_W'(IDX_ECAP))   kind = K_ECAP;
        else                                kind = K_OTHER;
    end
endmodule

// File: rtl/ibw_top.sv
module ibw_top
    import ibw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_size,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_ack,
    output logic [63:0]       cfg_rdata,
    output logic              err_pulse,
    output logic              dn_valid,
    output logic              dn_we,
    output logic [WIN_AW-1:0] dn_addr,
    output logic [63:0]       dn_wdata,
    input  logic              dn_ready,
    input  logic [63:0]       dn_rdata
);
    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(BYTES);
    localparam int IDX_W  = ADDR_W - OFF_W;
    localparam int STAT_W = 2;
    localparam logic [1:0] SIZE_FULL = 2'(OFF_W);

    ibw_state_e        state_q, state_d;
    ibw_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              legal;
    logic [DATA_W-1:0] wval, rd_src, rd_bus;
    logic [DATA_W-1:0] rdata_q, wdat_q;
    logic [WIN_AW-1:0] win_q;
    logic [STAT_W-1:0] stat_q;
    logic [IDX_W-1:0]  ecap_q;
    logic              err_q;
    logic              accept;

    assign idx    = cfg_addr[ADDR_W-1:OFF_W];
    assign legal  = (cfg_size == SIZE_FULL) && (cfg_addr[OFF_W-1:0] == '0);
    assign accept = (state_q == ST_IDLE) && cfg_req;

    ibw_decode #(.IDX_W(IDX_W)) u_dec (.idx(idx), .kind(kind));
    ibw_swap #(.BYTES(BYTES)) u_swin  (.din(cfg_wdata), .dout(wval));
    ibw_swap #(.BYTES(BYTES)) u_swout (.din(rd_src), .dout(rd_bus));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_req) begin
                if (legal && kind == K_WDATA) state_d = cfg_we ? ST_DNWR : ST_DNRD;
                else                          state_d = ST_RESP;
            end
            ST_DNRD: if (dn_ready) state_d = ST_RESP;
            ST_DNWR: if (dn_ready) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // register value presented for read (before lane swap)
    always_comb begin
        rd_src = '0;
        if (state_q == ST_DNRD) rd_src = dn_rdata;
        else begin
            unique case (kind)
                K_WADDR: rd_src = DATA_W'(win_q);
                K_STAT:  rd_src = DATA_W'(stat_q);
                K_ECAP:  rd_src = DATA_W'(ecap_q);
                default: rd_src = '0;
            endcase
        end
    end

    // register bank and access side effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            stat_q  <= '0;
            ecap_q  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
            wdat_q  <= '0;
        end else if (accept) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
            if (!legal) begin
                err_q     <= 1'b1;
                stat_q[0] <= 1'b1;
                ecap_q    <= idx;
            end else if (cfg_we) begin
                unique case (kind)
                    K_WADDR: win_q  <= wval[WIN_AW-1:0];
                    K_WDATA: wdat_q <= wval;
                    K_STAT:  stat_q <= stat_q & ~wval[STAT_W-1:0];
                    K_CTRL:  ;
                    default: begin
                        err_q     <= 1'b1;
                        stat_q[1] <= 1'b1;
                        ecap_q    <= idx;
                    end
                endcase
            end else if (kind != K_WDATA) begin
                rdata_q <= rd_bus;
            end
        end else if (state_q == ST_DNRD && dn_ready) begin
            rdata_q <= rd_bus;
        end
    end

    // outputs decoded from state
    always_comb begin
        cfg_ack  = (state_q == ST_RESP);
        dn_valid = (state_q == ST_DNRD) || (state_q == ST_DNWR);
        dn_we    = (state_q == ST_DNWR);
    end
    assign cfg_rdata = cfg_ack ? rdata_q : '0;
    assign err_pulse = cfg_ack && err_q;
    assign dn_addr   = win_q;
    assign dn_wdata  = wdat_q;

    // R6: a stalled downstream request holds its fields
    a_r6_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata));
    // R6: acknowledge lasts one cycle
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);
    // R6: window-data access acknowledges right after the downstream handshake
    a_r6_ack_after_dn: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_ready |=> cfg_ack && !dn_valid);
    // R9/R10: an error pulse rides on an acknowledge and leaves a status bit set
    a_r9_err_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> cfg_ack && (stat_q != '0));
    // R10: an illegal request never reaches the downstream port
    a_r10_no_dn_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !legal |=> !dn_valid && err_pulse);
    // R7: status bits only rise on a rejected access
    a_r7_status_source: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(stat_q)) != '0 |-> $past(accept) && err_q);
endmodule

// File: tb/sim_ibw_top.sv
`timescale 1ns/1ps
module sim_ibw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0, cfg_we = 1'b0;
    logic [1:0]  cfg_size = 2'd3;
    logic [15:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_ack, err_pulse, dn_valid, dn_we;
    logic [63:0] cfg_rdata, dn_wdata;
    logic [11:0] dn_addr;
    logic        dn_ready = 1'b0;
    logic [63:0] dn_rdata = '0;

    always #4 clk = ~clk;

    ibw_top u0 (.*);

    int n_run = 0, n_fail = 0;
    logic [63:0] mem [4096];
    int dn_cnt = 0;
    int dly = 0, wctr = 0;
    logic [11:0] m_win = '0;
    logic [1:0]  m_stat = '0;
    logic [12:0] m_ecap = '0;
    logic        done = 1'b0;

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // downstream responder and internal register model
    always @(negedge clk) begin
        if (dn_valid) begin
            dn_rdata <= mem[dn_addr];
            if (wctr == dly) dn_ready <= 1'b1;
            else begin dn_ready <= 1'b0; wctr <= wctr + 1; end
        end else begin
            dn_ready <= 1'b0;
            wctr <= 0;
        end
    end
    always @(posedge clk) begin
        if (rst_n && dn_valid && dn_ready) begin
            dn_cnt <= dn_cnt + 1;
            if (dn_we) mem[dn_addr] <= dn_wdata;
        end
    end

    task automatic acc(input logic we, input logic [1:0] sz, input logic [15:0] a,
                       input logic [63:0] wd, output logic [63:0] rd, output logic e, output int cyc);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_size = sz; cfg_addr = a; cfg_wdata = wd;
        cyc = 0; rd = '0; e = 1'b0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (cfg_ack) begin rd = cfg_rdata; e = err_pulse; break; end
            if (cyc > 40) break;
        end
        cfg_req = 1'b0;
    endtask

    // one access with model-computed expectations; v is the register value
    task automatic op(input logic we, input logic [1:0] sz, input logic [15:0] a,
                      input logic [63:0] v, input int d);
        logic [12:0] idx = a[15:3];
        logic legal = (sz == 2'd3) && (a[2:0] == 3'd0);
        logic [63:0] e_rd = '0, rd;
        logic e_err = 1'b0, err;
        int e_dn = 0, e_cyc = 1, cyc, dn0;
        string tg;
        dly = d;
        dn0 = dn_cnt;
        if (!legal) begin
            tg = "R10"; e_err = 1'b1; m_stat[0] = 1'b1; m_ecap = idx;
        end else if (idx == 13'd1) begin
            e_dn = 1; e_cyc = 2 + d;
            if (we) tg = "R5";
            else begin tg = "R4"; e_rd = bswap(mem[m_win]); end
        end else if (we) begin
            case (idx)
                13'd0: begin tg = "R3"; m_win = v[11:0]; end
                13'd2: begin tg = "R7"; m_stat = m_stat & ~v[1:0]; end
                13'd3, 13'd4: tg = "R8";
                default: begin tg = "R9"; e_err = 1'b1; m_stat[1] = 1'b1; m_ecap = idx; end
            endcase
        end else begin
            tg = "R11";
            case (idx)
                13'd0: e_rd = bswap({52'd0, m_win});
                13'd2: e_rd = bswap({62'd0, m_stat});
                13'd5: e_rd = bswap({51'd0, m_ecap});
                default: e_rd = '0;
            endcase
        end
        acc(we, sz, a, bswap(v), rd, err, cyc);
        if (!we) chk({tg, " read data"}, rd, e_rd);
        chk({tg, " error pulse"}, 64'(err), 64'(e_err));
        chk({tg, " downstream count"}, 64'(dn_cnt - dn0), 64'(e_dn));
        chk("R6 ack latency", 64'(cyc), 64'(e_cyc));
        if (legal && we && idx == 13'd1) chk("R5 internal value", mem[m_win], v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = {20'hC0FFE, 12'(i), 32'(i * 7919)};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", 64'(cfg_ack), 64'd0);
        chk("R1 dn_valid", 64'(dn_valid), 64'd0);
        chk("R1 err", 64'(err_pulse), 64'd0);
        op(0, 3, 16'h0000, 0, 0);
        op(0, 3, 16'h0010, 0, 0);
        op(0, 3, 16'h0028, 0, 0);
        // R3 low 12 bits kept, R2 lane order
        op(1, 3, 16'h0000, 64'hFFFF_FFFF_FFFF_F123, 0);
        chk("R3 dn_addr", 64'(dn_addr), 64'h123);
        op(0, 3, 16'h0000, 0, 0);
        // R2/R5 byte order into internal register, R4 read back
        op(1, 3, 16'h0008, 64'h1122_3344_5566_7788, 0);
        chk("R2 big-endian store", mem[12'h123], 64'h1122_3344_5566_7788);
        op(0, 3, 16'h0008, 0, 3);
        // R6 stalled writes
        op(1, 3, 16'h0008, 64'hDEAD_BEEF_0000_0001, 3);
        // R10 illegal size and misalignment
        op(0, 2, 16'h0008, 0, 0);
        op(1, 3, 16'h000C, 64'h5, 0);
        op(0, 3, 16'h0028, 0, 0);
        // R9 rejected writes, R7 clear
        op(1, 3, 16'h0028, 64'h77, 0);
        op(1, 3, 16'hFFF8, 64'h1, 0);
        op(0, 3, 16'h0028, 0, 0);
        op(0, 3, 16'h0010, 0, 0);
        op(1, 3, 16'h0010, 64'h1, 0);
        op(0, 3, 16'h0010, 0, 0);
        // R8 control writes ignored
        op(1, 3, 16'h0018, '1, 0);
        op(1, 3, 16'h0020, '1, 0);
        op(0, 3, 16'h0018, 0, 0);
        op(0, 3, 16'h0010, 0, 0);
        op(0, 3, 16'h0000, 0, 0);
        for (int k = 0; k < 600; k++) begin
            logic [15:0] a;
            logic [1:0] sz;
            a  = {10'(($urandom % 16 == 0) ? $urandom : 0), 3'($urandom % 8), 3'd0};
            sz = ($urandom % 10 == 0) ? 2'($urandom) : 2'd3;
            if ($urandom % 16 == 0) a[2:0] = 3'($urandom);
            op(1'($urandom), sz, a, {$urandom, $urandom}, int'($urandom % 4));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule